// File: doc/BRIEF.md
# System-bus address latch and region decoder

This block sits at the bus edge of a peripheral card. The upper seven address lines (bits 23:17 of a 24-bit, 16 MB space) arrive without a latch and are only trustworthy while the address strobe is high. The block decodes them at once into a one-bit hit for a single 128 KB region. It then freezes that hit, together with the lower 20 address bits, when the strobe falls, so the card sees a stable address and select for the rest of the bus cycle.

The strobe and the DMA ownership input are brought into the card's clock domain by a short register chain. The address buses pass through a delay chain of the same depth, so address and strobe stay aligned. While DMA owns the bus, the hold registers stay transparent and follow the address every cycle. A valid flag tells the card when the held address belongs to a real processor or DMA cycle.

Top module: `bus_addr_latch`

## Requirements
- R1: While `rst_n` is low, `hold_addr` is zero and `hold_hit` and `addr_valid` are low, whatever the address inputs carry.
- R2: The region hit is high exactly when `up_addr` (address bits 23:17) equals `REGION_BASE`; one bit away on either side gives no hit.
- R3: In a processor cycle (`dma_own` low), `hold_addr` and `hold_hit` keep the address and hit last seen with the strobe high, even if the address buses change together with the strobe's fall.
- R4: In a processor cycle, `addr_valid` goes high after the strobe falls.
- R5: In a processor cycle, `addr_valid` goes low when a new strobe rises.
- R6: While both the strobe and `dma_own` are low, `hold_addr` and `hold_hit` do not change, whatever the address buses do.
- R7: While `dma_own` is high, the hold registers follow the address every cycle, whatever level the strobe has, and `addr_valid` stays high.
- R8: When `dma_own` drops, `addr_valid` goes low and stays low until the next strobe fall.
- R9: With the strobe high, an address change driven before clock edge k shows on `hold_addr` after edge k+`SYNC_STAGES` and not after edge k+`SYNC_STAGES`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_addr | input | HI_W | Unlatched upper address bits 23:17 |
| low_addr | input | LO_W | Lower address bits 19:0 |
| addr_strobe | input | 1 | Address strobe, high while the address is valid |
| dma_own | input | 1 | High while a DMA controller owns the address |
| hold_addr | output | LO_W | Held lower address |
| hold_hit | output | 1 | Held region hit |
| addr_valid | output | 1 | Held address belongs to a valid cycle |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 and `REGION_BASE` set to 7'h0C. This makes the input-to-output latency four edges rather than the default three, so a fixed default depth that was wired in by mistake shows up as a latency error. A base away from the edges of the range lets the neighbours just above and below it be used as near-miss addresses. Address changes are driven in the same cycle as the strobe fall, the hardest case for the alignment of the delay chains.

// File: rtl/bal_pkg.sv
package bal_pkg;
  localparam int unsigned LO_W_DEF  = 20;
  localparam int unsigned HI_W_DEF  = 7;
  localparam int unsigned SYNC_DEF  = 2;
  localparam int unsigned RST_STAGES = 2;

  typedef enum logic [1:0] {
    VLD_HOLD  = 2'd0,
    VLD_SET   = 2'd1,
    VLD_CLEAR = 2'd2
  } vld_act_e;
endpackage

// File: rtl/bal_pipe.sv
module bal_pipe #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stg_d[g] = d;
    end else begin : g_next
      always_comb stg_d[g] = stg_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_d[g];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/bal_region_dec.sv
module bal_region_dec #(
  parameter int unsigned      HI_W = 7,
  parameter logic [HI_W-1:0]  BASE = '0
) (
  input  logic [HI_W-1:0] hi,
  output logic            hit
);
  logic [HI_W-1:0] bit_eq;

  for (genvar g = 0; g < HI_W; g++) begin : g_bit
    assign bit_eq[g] = ~(hi[g] ^ BASE[g]);
  end

  assign hit = &bit_eq;
endmodule

// File: rtl/bal_capture.sv
module bal_capture
  import bal_pkg::*;
#(
  parameter int unsigned LO_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic            dma,
  input  logic [LO_W-1:0] addr,
  input  logic            hit,
  output logic [LO_W-1:0] hold_addr,
  output logic            hold_hit,
  output logic            valid
);
  logic            stb_prev_q, dma_prev_q;
  logic            stb_rise, stb_fall, dma_fall;
  logic            load_en;
  vld_act_e        vld_act;
  logic [LO_W-1:0] addr_q, addr_n;
  logic            hit_q, hit_n;
  logic            vld_q, vld_n;

  // edge detection against the previous sample
  always_comb begin
    stb_rise = stb & ~stb_prev_q;
    stb_fall = ~stb & stb_prev_q;
    dma_fall = ~dma & dma_prev_q;
  end

  // transparent while strobe high or DMA owns the bus
  always_comb begin
    load_en = stb | dma;
    addr_n  = addr_q;
    hit_n   = hit_q;
    if (load_en) begin
      addr_n = addr;
      hit_n  = hit;
    end
  end

  always_comb begin
    if (dma)                        vld_act = VLD_SET;
    else if (stb_rise || dma_fall)  vld_act = VLD_CLEAR;
    else if (stb_fall)              vld_act = VLD_SET;
    else                            vld_act = VLD_HOLD;

    unique case (vld_act)
      VLD_SET:   vld_n = 1'b1;
      VLD_CLEAR: vld_n = 1'b0;
      default:   vld_n = vld_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= 1'b0;
      dma_prev_q <= 1'b0;
      addr_q     <= '0;
      hit_q      <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      stb_prev_q <= stb;
      dma_prev_q <= dma;
      addr_q     <= addr_n;
      hit_q      <= hit_n;
      vld_q      <= vld_n;
    end
  end

  assign hold_addr = addr_q;
  assign hold_hit  = hit_q;
  assign valid     = vld_q;
endmodule

// File: rtl/bus_addr_latch.sv
module bus_addr_latch
  import bal_pkg::*;
#(
  parameter int unsigned     LO_W        = LO_W_DEF,
  parameter int unsigned     HI_W        = HI_W_DEF,
  parameter int unsigned     SYNC_STAGES = SYNC_DEF,
  parameter logic [HI_W-1:0] REGION_BASE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] up_addr,
  input  logic [LO_W-1:0] low_addr,
  input  logic            addr_strobe,
  input  logic            dma_own,
  output logic [LO_W-1:0] hold_addr,
  output logic            hold_hit,
  output logic            addr_valid
);
  localparam int unsigned BUS_W = LO_W + HI_W;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [1:0]            ctl_d;
  logic                  stb_d, dma_d;
  logic [BUS_W-1:0]      bus_d;
  logic [LO_W-1:0]       addr_d;
  logic [HI_W-1:0]       hi_d;
  logic                  hit_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  bal_pipe #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({dma_own, addr_strobe}),
    .q     (ctl_d)
  );
  assign stb_d = ctl_d[0];
  assign dma_d = ctl_d[1];

  bal_pipe #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_bus_dly (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({up_addr, low_addr}),
    .q     (bus_d)
  );
  assign addr_d = bus_d[LO_W-1:0];
  assign hi_d   = bus_d[BUS_W-1:LO_W];

  bal_region_dec #(.HI_W(HI_W), .BASE(REGION_BASE)) u_dec (
    .hi  (hi_d),
    .hit (hit_d)
  );

  bal_capture #(.LO_W(LO_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .stb       (stb_d),
    .dma       (dma_d),
    .addr      (addr_d),
    .hit       (hit_d),
    .hold_addr (hold_addr),
    .hold_hit  (hold_hit),
    .valid     (addr_valid)
  );
endmodule

// File: rtl/bal_checker.sv
module bal_checker #(
  parameter int unsigned     LO_W = 20,
  parameter int unsigned     HI_W = 7,
  parameter logic [HI_W-1:0] BASE = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stb_d,
  input logic            dma_d,
  input logic [LO_W-1:0] addr_d,
  input logic [HI_W-1:0] hi_d,
  input logic [LO_W-1:0] hold_addr,
  input logic            hold_hit,
  input logic            addr_valid
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (hold_addr == '0 && !hold_hit && !addr_valid);
    end
  end

  p_dma_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_d |=> hold_hit == ($past(hi_d) == BASE));

  p_fall_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stb_d) && !dma_d) |=> addr_valid);

  p_rise_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stb_d) && !dma_d) |=> !addr_valid);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_d && !dma_d) |=> ($stable(hold_addr) && $stable(hold_hit)));

  p_dma_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_d |=> (hold_addr == $past(addr_d) && addr_valid));

  p_dma_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_d) |=> !addr_valid);
endmodule

bind bus_addr_latch bal_checker #(
  .LO_W (LO_W),
  .HI_W (HI_W),
  .BASE (REGION_BASE)
) u_bal_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .stb_d      (stb_d),
  .dma_d      (dma_d),
  .addr_d     (addr_d),
  .hi_d       (hi_d),
  .hold_addr  (hold_addr),
  .hold_hit   (hold_hit),
  .addr_valid (addr_valid)
);

// File: tb/test_bus_addr_latch.sv
module test_bus_addr_latch;
  localparam int unsigned     LO_W = 20;
  localparam int unsigned     HI_W = 7;
  localparam int unsigned     S    = 3;
  localparam int unsigned     L    = S + 1;
  localparam logic [HI_W-1:0] BASE = 7'h0C;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [HI_W-1:0] up_addr;
  logic [LO_W-1:0] low_addr;
  logic            addr_strobe;
  logic            dma_own;
  logic [LO_W-1:0] hold_addr;
  logic            hold_hit;
  logic            addr_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    string           tag;
    logic [LO_W-1:0] a;
    logic            s;
    logic            v;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  bus_addr_latch #(
    .LO_W        (LO_W),
    .HI_W        (HI_W),
    .SYNC_STAGES (S),
    .REGION_BASE (BASE)
  ) i_bus_addr_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_addr     (up_addr),
    .low_addr    (low_addr),
    .addr_strobe (addr_strobe),
    .dma_own     (dma_own),
    .hold_addr   (hold_addr),
    .hold_hit    (hold_hit),
    .addr_valid  (addr_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string tag, input logic [LO_W-1:0] a,
                      input logic s, input logic v);
    exp_t e;
    e.tag = tag; e.a = a; e.s = s; e.v = v;
    sb.push_back(e);
    cyc(2);
  endtask

  // monitor: compares queued expectations with the outputs
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(hold_addr == e.a, {e.tag, " addr"}, 32'(hold_addr), 32'(e.a));
      chk(hold_hit == e.s, {e.tag, " hit"}, 32'(hold_hit), 32'(e.s));
      chk(addr_valid == e.v, {e.tag, " valid"}, 32'(addr_valid), 32'(e.v));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    up_addr     = BASE;
    low_addr    = 20'hABCDE;
    addr_strobe = 1'b1;
    dma_own     = 1'b1;
    cyc(4);
    chk(hold_addr == '0, "R1 addr", 32'(hold_addr), 32'h0);
    chk(!hold_hit, "R1 hit", 32'(hold_hit), 32'h0);
    chk(!addr_valid, "R1 valid", 32'(addr_valid), 32'h0);
    addr_strobe = 1'b0;
    dma_own     = 1'b0;
    up_addr     = '0;
    low_addr    = '0;
    rst_n       = 1'b1;
    cyc(6);

    // processor cycle, address changes together with the strobe fall
    up_addr = BASE; low_addr = 20'h12345; addr_strobe = 1'b1;
    cyc(L + 3);
    addr_strobe = 1'b0; up_addr = '0; low_addr = 20'hFFFFF;
    cyc(L + 3);
    push("R3 R4 capture", 20'h12345, 1'b1, 1'b1);
    low_addr = 20'h55555; up_addr = BASE;
    cyc(L + 3);
    push("R6 idle hold", 20'h12345, 1'b1, 1'b1);

    // new strobe clears valid
    up_addr = BASE + 7'd1; low_addr = 20'h00ABC; addr_strobe = 1'b1;
    cyc(L + 2);
    push("R5 rise clear", 20'h00ABC, 1'b0, 1'b0);

    // latency while transparent
    low_addr = 20'h0F0F0;
    cyc(S);
    chk(hold_addr == 20'h00ABC, "R9 early", 32'(hold_addr), 32'h00ABC);
    cyc(1);
    chk(hold_addr == 20'h0F0F0, "R9 on time", 32'(hold_addr), 32'h0F0F0);

    // region decode boundaries
    up_addr = BASE - 7'd1;
    cyc(L + 1);
    chk(!hold_hit, "R2 below base", 32'(hold_hit), 32'h0);
    up_addr = BASE;
    cyc(L + 1);
    chk(hold_hit, "R2 at base", 32'(hold_hit), 32'h1);
    up_addr = BASE + 7'd1;
    cyc(L + 1);
    chk(!hold_hit, "R2 above base", 32'(hold_hit), 32'h0);
    addr_strobe = 1'b0;
    cyc(L + 2);
    push("R4 fall set", 20'h0F0F0, 1'b0, 1'b1);

    // DMA ownership: transparent regardless of strobe
    dma_own = 1'b1; addr_strobe = 1'b1; low_addr = 20'h11111; up_addr = BASE;
    cyc(L + 1);
    push("R7 dma strobe high", 20'h11111, 1'b1, 1'b1);
    addr_strobe = 1'b0; low_addr = 20'h22222; up_addr = '0;
    cyc(L + 1);
    push("R7 dma strobe low", 20'h22222, 1'b0, 1'b1);
    dma_own = 1'b0;
    cyc(L + 2);
    push("R8 dma drop", 20'h22222, 1'b0, 1'b0);

    dma_own = 1'b1; addr_strobe = 1'b1; low_addr = 20'h33333;
    cyc(L + 2);
    dma_own = 1'b0;
    cyc(L + 2);
    push("R8 drop strobe high", 20'h33333, 1'b0, 1'b0);
    addr_strobe = 1'b0;
    cyc(L + 2);
    push("R4 after dma", 20'h33333, 1'b0, 1'b1);

    cyc(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule